// File: doc/BRIEF.md
# Tagged Receive FIFO with Per-Origin Request Flags

This block is the receive queue between a host bus interface and a local processor core. Every 24-bit word pushed into the queue carries a one-bit origin tag. The tag says whether the interface fetched the word while it was driving the bus as master, or whether an external host wrote the word into it as a slave target. The core pops words from the queue one at a time. Each popped word appears on a registered read port together with its tag.

In place of a single "not empty" indication, the block drives two request flags. Each flag follows the tag of the word now at the head of the queue. The master flag can also raise an interrupt request and a DMA request, each gated by its own enable input. A push into a full queue is dropped and sets a sticky overflow indication. Either a hardware reset or a software reset empties the queue and clears all flags.

Top module: `tagged_rx_fifo`

## Requirements
- R1: Words leave the queue in the order they were pushed. A pop of a non-empty queue loads the head word into `rd_data` at that clock edge, so the word is visible from the next cycle on.
- R2: `rd_tag` is loaded together with `rd_data` and holds the origin tag of the popped word (1 = fetched as bus master, 0 = written by a host as slave).
- R3: `master_req` is high exactly when the queue is not empty and the head word has tag 1. It falls when the head becomes a tag-0 word or when pops empty the queue.
- R4: `slave_req` is high exactly when the queue is not empty and the head word has tag 0. `master_req` and `slave_req` are never high together, and both are low when the queue is empty.
- R5: `master_irq` is high exactly when `master_req` and `irq_en` are both high.
- R6: `master_dma` is high exactly when `master_req` and `dma_en` are both high.
- R7: The asynchronous hardware reset (`rst_n` low) and the synchronous software reset (`soft_rst` high at a clock edge) each empty the queue, clear both request flags and `overflow`, and set `rd_data` and `rd_tag` to zero.
- R8: A pop of an empty queue has no effect: `rd_data`, `rd_tag` and the flags keep their values.
- R9: A push while `full` is high is dropped, and the queued contents stay unchanged. The push sets `overflow`, which stays high until a hardware or software reset.
- R10: The queue holds DEPTH = 8 entries. `full` rises after the eighth push into an empty queue. Request flags and `full` reflect a push or pop from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| push | input | 1 | Write a word into the queue |
| push_data | input | 24 | Word to write |
| push_tag | input | 1 | Origin of the word: 1 master fetch, 0 slave write |
| pop | input | 1 | Core read of the head word |
| irq_en | input | 1 | Enable for the master receive interrupt |
| dma_en | input | 1 | Enable for the master receive DMA request |
| rd_data | output | 24 | Last word popped |
| rd_tag | output | 1 | Tag of the last word popped |
| full | output | 1 | Queue holds DEPTH words |
| master_req | output | 1 | Head word is master data |
| slave_req | output | 1 | Head word is slave data |
| master_irq | output | 1 | Master receive interrupt request |
| master_dma | output | 1 | Master receive DMA request |
| overflow | output | 1 | Sticky: a push into a full queue was dropped |

## Verification
On every cycle, the assertions check several properties. The two request flags are mutually exclusive and both stay low on an empty queue. The interrupt and DMA requests never appear without a head word. A dropped push leaves the queue full, and a pop of an empty queue leaves the read port stable. Overflow persists until a reset, and a software reset clears the queue.

Only the bench's scenarios can show that data and tags come out in push order, and that the flags track each successive head tag. The bench sweeps all 256 tag patterns over a full queue and rotates the enable combinations. For each pattern, after the last pop it checks the read port hold and the software reset.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_DEPTH  = 8;

  // Tag encoding carried beside every word.
  localparam logic TAG_MASTER = 1'b1;
  localparam logic TAG_SLAVE  = 1'b0;

  // Circular pointer advance for any depth (no power-of-two assumption).
  function automatic int unsigned ptr_advance(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned occ_next(int unsigned occ, logic inc, logic dec);
    return occ + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = rxq_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = rxq_pkg::DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_tag,
  output logic              empty,
  output logic              full,
  output logic              push_ok,
  output logic              push_drop,
  output logic              pop_ok
);
  import rxq_pkg::*;

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;

  assign empty     = (occ == '0);
  assign full      = (occ == CW'(DEPTH));
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;

  // One write strobe per entry, tag stored as the top bit.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic we;
    assign we = push_ok && (wr_ptr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[g] <= '0;
      else if (we)     mem[g] <= {push_tag, push_data};
    end
  end

  assign head_tag  = mem[rd_ptr][EW-1];
  assign head_data = mem[rd_ptr][DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_advance(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_advance(int'(rd_ptr), DEPTH));
      occ <= CW'(occ_next(int'(occ), push_ok, pop_ok));
    end
  end

  // R9: a dropped push (no pop) leaves the queue full.
  a_r9_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop && !soft_rst) |=> full);

  // R10: occupancy never exceeds the depth.
  a_r10_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R7: software reset empties the queue.
  a_r7_soft_empties: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> empty);

endmodule

// File: rtl/rxq_out.sv
module rxq_out #(
  parameter int unsigned DATA_W = rxq_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pop_ok,
  input  logic              pop,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_tag  <= 1'b0;
    end else if (soft_rst) begin
      rd_data <= '0;
      rd_tag  <= 1'b0;
    end else if (pop_ok) begin
      rd_data <= head_data;
      rd_tag  <= head_tag;
    end
  end

  // R8: popping an empty queue leaves the read port unchanged.
  a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !soft_rst) |=> ($stable(rd_data) && $stable(rd_tag)));

endmodule

// File: rtl/rxq_req.sv
module rxq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic empty,
  input  logic head_tag,
  input  logic push_drop,
  input  logic irq_en,
  input  logic dma_en,
  output logic master_req,
  output logic slave_req,
  output logic master_irq,
  output logic master_dma,
  output logic overflow
);
  import rxq_pkg::*;

  assign master_req = !empty && (head_tag == TAG_MASTER);
  assign slave_req  = !empty && (head_tag == TAG_SLAVE);
  assign master_irq = master_req && irq_en;
  assign master_dma = master_req && dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overflow <= 1'b0;
    else if (soft_rst)   overflow <= 1'b0;
    else if (push_drop)  overflow <= 1'b1;
  end

  // R4: the two request flags are mutually exclusive.
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_req && slave_req));

  // R4: nothing is requested while the queue is empty.
  a_r4_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!master_req && !slave_req));

  // R5 and R6: the interrupt and DMA requests need a head word.
  a_r5_irq_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    master_irq |-> !empty);
  a_r6_dma_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    master_dma |-> !empty);

  // R9: overflow stays set until a reset.
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !soft_rst) |=> overflow);

  // R7: software reset clears overflow.
  a_r7_soft_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !overflow);

endmodule

// File: rtl/tagged_rx_fifo.sv
module tagged_rx_fifo #(
  parameter int unsigned DATA_W = rxq_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = rxq_pkg::DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  input  logic              pop,
  input  logic              irq_en,
  input  logic              dma_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              full,
  output logic              master_req,
  output logic              slave_req,
  output logic              master_irq,
  output logic              master_dma,
  output logic              overflow
);

  // Internal events, named for the assertions.
  logic [DATA_W-1:0] head_data;
  logic              head_tag;
  logic              empty;
  logic              push_ok;
  logic              push_drop;
  logic              pop_ok;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .push      (push),
    .push_data (push_data),
    .push_tag  (push_tag),
    .pop       (pop),
    .head_data (head_data),
    .head_tag  (head_tag),
    .empty     (empty),
    .full      (full),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .pop_ok    (pop_ok)
  );

  rxq_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .pop_ok    (pop_ok),
    .pop       (pop),
    .empty     (empty),
    .head_data (head_data),
    .head_tag  (head_tag),
    .rd_data   (rd_data),
    .rd_tag    (rd_tag)
  );

  rxq_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .empty      (empty),
    .head_tag   (head_tag),
    .push_drop  (push_drop),
    .irq_en     (irq_en),
    .dma_en     (dma_en),
    .master_req (master_req),
    .slave_req  (slave_req),
    .master_irq (master_irq),
    .master_dma (master_dma),
    .overflow   (overflow)
  );

  // R1: an accepted push makes the queue non-empty on the next cycle.
  a_r1_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !soft_rst) |=> (master_req || slave_req));

endmodule

// File: tb/tagged_rx_fifo_tb.sv
module tagged_rx_fifo_tb;

  localparam int DW = 24;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          push = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          push_tag = 1'b0;
  logic          pop = 1'b0;
  logic          irq_en = 1'b0;
  logic          dma_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_tag, full, master_req, slave_req, master_irq, master_dma, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  tagged_rx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .push(push), .push_data(push_data), .push_tag(push_tag), .pop(pop),
    .irq_en(irq_en), .dma_en(dma_en),
    .rd_data(rd_data), .rd_tag(rd_tag), .full(full),
    .master_req(master_req), .slave_req(slave_req),
    .master_irq(master_irq), .master_dma(master_dma), .overflow(overflow)
  );

  function automatic logic [DW-1:0] word_of(int p, int i);
    return {8'(p), 8'(i * 37 + 11), 8'(p ^ 8'hA5)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive for one edge; returns at the following falling edge.
  task automatic do_push(logic [DW-1:0] d, logic t);
    push = 1'b1; push_data = d; push_tag = t;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_soft();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic check_flags(string tag, bit nonempty, bit head_master);
    check({tag, " R3 master_req"}, 32'(master_req), 32'(nonempty && head_master));
    check({tag, " R4 slave_req"},  32'(slave_req),  32'(nonempty && !head_master));
    check({tag, " R5 master_irq"}, 32'(master_irq), 32'(nonempty && head_master && irq_en));
    check({tag, " R6 master_dma"}, 32'(master_dma), 32'(nonempty && head_master && dma_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: hardware reset state
    check("R7 rd_data after hw reset", 32'(rd_data), 0);
    check("R7 overflow after hw reset", 32'(overflow), 0);
    check("R10 full after hw reset", 32'(full), 0);
    check_flags("R7 hw reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 256; p++) begin
      irq_en = p[0];
      dma_en = p[1];
      for (int i = 0; i < DEPTH; i++) begin
        do_push(word_of(p, i), p[i]);
        check_flags("R3/R4 head after push", 1, p[0]);
        check("R10 full while filling", 32'(full), 32'(i == DEPTH - 1));
      end
      // R9: push into a full queue is dropped
      do_push(24'hFFFFFF, ~p[7]);
      check("R9 overflow set", 32'(overflow), 1);
      check("R9 still full", 32'(full), 1);
      for (int i = 0; i < DEPTH; i++) begin
        check_flags("R3/R4 head before pop", 1, p[i]);
        do_pop();
        check("R1 rd_data order", 32'(rd_data), 32'(word_of(p, i)));
        check("R2 rd_tag", 32'(rd_tag), 32'(p[i]));
        check("R9 overflow sticky", 32'(overflow), 1);
      end
      check_flags("R3 drained", 0, 0);
      // R8: pop on empty holds the read port
      do_pop();
      check("R8 rd_data holds", 32'(rd_data), 32'(word_of(p, DEPTH - 1)));
      check("R8 rd_tag holds", 32'(rd_tag), 32'(p[DEPTH - 1]));
      check_flags("R8 empty pop", 0, 0);
      // R7: software reset
      do_push(word_of(p, 3), p[2]);
      do_soft();
      check("R7 soft overflow", 32'(overflow), 0);
      check("R7 soft rd_data", 32'(rd_data), 0);
      check("R7 soft rd_tag", 32'(rd_tag), 0);
      check_flags("R7 soft", 0, 0);
    end

    // R7: hardware reset in the middle of traffic
    irq_en = 1'b1; dma_en = 1'b1;
    do_push(24'h123456, 1'b1);
    do_push(24'h654321, 1'b0);
    do_pop();
    check("R1 rd_data before hw reset", 32'(rd_data), 32'h123456);
    check_flags("R4 slave head", 1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 hw rd_data", 32'(rd_data), 0);
    check_flags("R7 hw mid-run", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule